// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This peripheral keeps a 32-bit count of seconds. A prescaler divides the system clock down to a one-pulse-per-second enable, and each pulse advances the count by one. Software can overwrite the count, stop and restart it, and program a compare value. When the count reaches that compare value, a sticky status bit is set. A mask bit then decides whether the level-type interrupt line follows that status. The design treats the clock as exact: a compare value of the current count plus N fires N seconds later.

Access is through a small register bus. There is a 3-bit word index, a write strobe, write data, and combinational read data. The byte offset of a register is four times its word index. The match status is held by a two-state machine. `ST_IDLE` means no match is pending. `ST_HIT` means a match is latched. The machine moves from `ST_IDLE` to `ST_HIT` on a compare hit. It moves from `ST_HIT` back to `ST_IDLE` on a clear write with no hit in the same cycle. It stays in `ST_HIT` when a hit and a clear arrive together. The parameter `CLKS_PER_SEC` (at least 2) sets the length of one second in system clocks.

Top module: `sec_match_timer`

## Requirements
- R1: After reset the count, compare and load registers read 0, the control register reads 1, the mask, raw status and masked status read 0, and `irq_o` is low.
- R2: The word index selects a register as follows: 0 count (read-only), 1 compare, 2 load, 3 control, 4 mask, 5 raw status, 6 masked status, 7 clear (write-only). Bits 31:1 of the control, mask, raw and masked registers read 0, and the clear register always reads 0. Compare and load read back the last value written.
- R3: While control bit 0 is 1, the count rises by exactly one every `CLKS_PER_SEC` clocks. The first step comes `CLKS_PER_SEC` clocks after the edge that loaded the count or set the enable.
- R4: While control bit 0 is 0, the count holds its value and the prescaler stays at its start.
- R5: A write to the load register puts the written value into the count at that clock edge and restarts the prescaler. A load takes precedence over a tick in the same cycle.
- R6: Raw status bit 0 is set in the cycle the count takes a new value (by tick or by load) equal to the compare value, whatever the mask. Writing a compare value equal to the count as it stands does not set it.
- R7: Raw status stays set until it is cleared, even after the count has moved past the compare value.
- R8: Masked status bit 0 is raw bit 0 AND mask bit 0, and `irq_o` is a level equal to that masked bit.
- R9: A write to the clear register with data bit 0 set clears raw status. A write to the clear register with data bit 0 clear has no effect.
- R10: If a clear write and a new compare hit land on the same edge, raw status ends up set.
- R11: Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word index of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt, high while masked status is set |

## Verification
The bench counts clock edges after each load and each enable. It confirms that the step lands on the `CLKS_PER_SEC`-th edge and not one early or late; an off-by-one divider shows up as a wrong count at those edges.

It sets up a clear and a compare hit on the same edge, so a design that lets the clear win loses the interrupt. It also checks a load straight onto the compare value, which catches a comparator that looks only at ticks. A compare write equal to the standing count must not fire, which catches a comparator that is evaluated all the time.

Stickiness is probed after the count has moved on. The bench also writes the clear register with bit 0 low. Toggling the mask shows whether `irq_o` really follows raw AND mask, and whether the raw bit survives while the interrupt is masked.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_COUNT  = 3'd0,
        RG_MATCH  = 3'd1,
        RG_LOAD   = 3'd2,
        RG_CTRL   = 3'd3,
        RG_MASK   = 3'd4,
        RG_RAW    = 3'd5,
        RG_MASKED = 3'd6,
        RG_CLEAR  = 3'd7
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIT  = 1'b1
    } match_state_e;

endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
    parameter int unsigned CLKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DIV_W = (CLKS_PER_SEC > 2) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_SEC - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || !run || (div_q == LAST)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && !restart && (div_q == LAST);

endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] match_val,
    output logic [DATA_W-1:0] count,
    output logic              hit
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] count_d;
    logic              upd;

    always_comb begin
        upd     = load_en || tick;
        count_d = load_en ? load_val : (count_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (upd) begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
    assign hit   = upd && (count_d == match_val);

endmodule

// File: rtl/sec_match_status.sv
module sec_match_status
    import sec_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic raw
);
    match_state_e state_q;
    match_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)         state_d = ST_HIT;
            ST_HIT:  if (clr && !hit) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        raw = (state_q == ST_HIT);
    end

endmodule

// File: rtl/sec_match_timer.sv
module sec_match_timer
    import sec_timer_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned CLKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam logic [DATA_W-2:0] HI_ZERO = '0;

    reg_sel_e          sel;
    logic              wr_match, wr_load, wr_ctrl, wr_mask, wr_clear;
    logic [DATA_W-1:0] match_q, load_q, count_q;
    logic              ctrl_en_q, mask_q;
    logic              sec_tick, cmp_hit, raw_st;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_match = bus_we && (sel == RG_MATCH);
    assign wr_load  = bus_we && (sel == RG_LOAD);
    assign wr_ctrl  = bus_we && (sel == RG_CTRL);
    assign wr_mask  = bus_we && (sel == RG_MASK);
    assign wr_clear = bus_we && (sel == RG_CLEAR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q   <= '0;
            load_q    <= '0;
            ctrl_en_q <= 1'b1;
            mask_q    <= 1'b0;
        end else begin
            if (wr_match) match_q   <= bus_wdata;
            if (wr_load)  load_q    <= bus_wdata;
            if (wr_ctrl)  ctrl_en_q <= bus_wdata[0];
            if (wr_mask)  mask_q    <= bus_wdata[0];
        end
    end

    sec_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_en_q),
        .restart (wr_load),
        .tick    (sec_tick)
    );

    sec_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load_en   (wr_load),
        .load_val  (bus_wdata),
        .match_val (match_q),
        .count     (count_q),
        .hit       (cmp_hit)
    );

    sec_match_status u_st (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cmp_hit),
        .clr   (wr_clear && bus_wdata[0]),
        .raw   (raw_st)
    );

    assign irq_o = raw_st && mask_q;

    always_comb begin
        unique case (sel)
            RG_COUNT:  bus_rdata = count_q;
            RG_MATCH:  bus_rdata = match_q;
            RG_LOAD:   bus_rdata = load_q;
            RG_CTRL:   bus_rdata = {HI_ZERO, ctrl_en_q};
            RG_MASK:   bus_rdata = {HI_ZERO, mask_q};
            RG_RAW:    bus_rdata = {HI_ZERO, raw_st};
            RG_MASKED: bus_rdata = {HI_ZERO, raw_st && mask_q};
            RG_CLEAR:  bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_match_timer_chk.sv
module sec_match_timer_chk
    import sec_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic [DATA_W-1:0] count,
    input logic              raw,
    input logic              mask,
    input logic              en,
    input logic              hit
);
    logic ld_wr, clr1_wr;
    assign ld_wr   = bus_we && (bus_addr == RG_LOAD);
    assign clr1_wr = bus_we && (bus_addr == RG_CLEAR) && bus_wdata[0];

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> (count == $past(bus_wdata)));

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld_wr) |=> $stable(count));

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_wr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

    // R6
    hit_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);

    // R7
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr1_wr) |=> raw);

    // R9
    clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr1_wr && !hit) |=> !raw);

    // R8
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask && raw));

    // R8
    irq_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && raw) |-> irq_o);

endmodule

bind sec_match_timer sec_match_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .count     (count_q),
    .raw       (raw_st),
    .mask      (mask_q),
    .en        (ctrl_en_q),
    .hit       (cmp_hit)
);

// File: tb/sec_match_timer_bench.sv
module sec_match_timer_bench;
    localparam int CLK_PERIOD = 20;
    localparam int DW         = 32;

    localparam logic [2:0] A_COUNT = 3'd0, A_MATCH = 3'd1, A_LOAD = 3'd2, A_CTRL = 3'd3,
                           A_MASK = 3'd4, A_RAW = 3'd5, A_MASKED = 3'd6, A_CLEAR = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    bus_addr;
    logic          bus_we;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_match_timer #(.DATA_W(DW), .CLKS_PER_SEC(4)) u_sec_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: pops expected items and compares against the design outputs.
    always @(sb_ev) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Driver side: push an expectation; the monitor compares it right away.
    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        sb_item_t it;
        #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(A_COUNT,  32'd0, "R1 count");
        expect_rd(A_MATCH,  32'd0, "R1 match");
        expect_rd(A_LOAD,   32'd0, "R1 load");
        expect_rd(A_CTRL,   32'd1, "R1 ctrl");
        expect_rd(A_MASK,   32'd0, "R1 mask");
        expect_rd(A_RAW,    32'd0, "R1 raw");
        expect_rd(A_MASKED, 32'd0, "R1 masked");
        expect_irq(1'b0, "R1 irq");

        // R5 load, R3 stepping
        wr(A_LOAD, 32'd100);
        expect_rd(A_COUNT, 32'd100, "R5 load value");
        idle(3);
        expect_rd(A_COUNT, 32'd100, "R3 no early step");
        idle(1);
        expect_rd(A_COUNT, 32'd101, "R3 first step");
        idle(4);
        expect_rd(A_COUNT, 32'd102, "R3 second step");
        expect_rd(A_LOAD, 32'd100, "R2 load readback");

        // R4 disabled holds
        wr(A_CTRL, 32'd0);
        wr(A_LOAD, 32'd500);
        idle(10);
        expect_rd(A_COUNT, 32'd500, "R4 hold");
        expect_rd(A_CTRL, 32'd0, "R4 ctrl off");

        // R6 match with mask off
        wr(A_LOAD, 32'd1000);
        wr(A_MATCH, 32'd1002);
        expect_rd(A_MATCH, 32'd1002, "R2 match readback");
        wr(A_CTRL, 32'd1);
        expect_rd(A_COUNT, 32'd1000, "R3 enable edge");
        idle(3);
        expect_rd(A_COUNT, 32'd1000, "R3 after enable");
        idle(1);
        expect_rd(A_COUNT, 32'd1001, "R3 first after enable");
        idle(3);
        expect_rd(A_RAW, 32'd0, "R6 before match");
        idle(1);
        expect_rd(A_COUNT, 32'd1002, "R3 at match");
        expect_rd(A_RAW, 32'd1, "R6 raw set unmasked");
        expect_rd(A_MASKED, 32'd0, "R8 masked off");
        expect_irq(1'b0, "R8 irq off when masked");

        // R7 sticky
        idle(8);
        expect_rd(A_COUNT, 32'd1004, "R3 past match");
        expect_rd(A_RAW, 32'd1, "R7 sticky");

        // R8 mask
        wr(A_MASK, 32'd1);
        expect_rd(A_MASKED, 32'd1, "R8 masked on");
        expect_irq(1'b1, "R8 irq on");
        // R9 clear with bit0 low
        wr(A_CLEAR, 32'd2);
        expect_rd(A_RAW, 32'd1, "R9 no clear on bit0 low");
        expect_irq(1'b1, "R9 irq kept");
        wr(A_MASK, 32'd0);
        expect_irq(1'b0, "R8 irq masked");
        expect_rd(A_RAW, 32'd1, "R8 raw kept while masked");
        wr(A_MASK, 32'd1);
        expect_irq(1'b1, "R8 irq unmasked");
        wr(A_CLEAR, 32'd1);
        expect_rd(A_RAW, 32'd0, "R9 cleared");
        expect_irq(1'b0, "R9 irq dropped");
        expect_rd(A_CLEAR, 32'd0, "R2 clear reads zero");

        // R10 clear and hit on the same edge
        wr(A_CTRL, 32'd0);
        wr(A_LOAD, 32'd2000);
        wr(A_MATCH, 32'd2001);
        wr(A_CTRL, 32'd1);
        idle(2);
        wr(A_CLEAR, 32'd1);
        expect_rd(A_COUNT, 32'd2001, "R10 count at hit");
        expect_rd(A_RAW, 32'd1, "R10 hit wins");
        expect_irq(1'b1, "R10 irq");

        // R6 load onto match value
        wr(A_CTRL, 32'd0);
        wr(A_MATCH, 32'd3000);
        wr(A_CLEAR, 32'd1);
        expect_rd(A_RAW, 32'd0, "R9 cleared before load");
        wr(A_LOAD, 32'd3000);
        expect_rd(A_RAW, 32'd1, "R6 load hits match");

        // R6 match write equal to standing count does not fire
        wr(A_LOAD, 32'd3100);
        wr(A_CLEAR, 32'd1);
        wr(A_MATCH, 32'd3100);
        idle(2);
        expect_rd(A_RAW, 32'd0, "R6 match write no fire");

        // R11 count register is read-only
        wr(A_COUNT, 32'hDEAD_BEEF);
        expect_rd(A_COUNT, 32'd3100, "R11 write ignored");

        // R2 reserved bits
        wr(A_CTRL, 32'hFFFF_FFFF);
        expect_rd(A_CTRL, 32'd1, "R2 ctrl upper zero");
        wr(A_MASK, 32'hFFFF_FFFE);
        expect_rd(A_MASK, 32'd0, "R2 mask bit0 only");
        expect_rd(A_MASKED, 32'd0, "R2 masked upper zero");

        done = 1;
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule